// File: doc/BRIEF.md
# One-Shot Countdown Timer with Power-of-Two Prescale

This block counts a loaded value down to zero, one step per tick, and a tick lasts sixteen clock cycles times a selectable power of two. Software reaches it through a small register port. It writes a start value into the load register, picks the tick length through a 4-bit divide register, and reads the remaining tick count back at any time. When the count runs out, the block raises a single-cycle expiry strobe. The count then stays at zero until the next load.

The divide register uses an uneven code. Bit 3 and bits 1:0 together form a 3-bit number. That number plus one, wrapped modulo 8, is the shift applied to the fixed prescale of sixteen. The divisor is captured when a start value is written, so a countdown already in progress keeps its tick length. Reset is asynchronous and active low, and the block releases it on a clock edge through an internal synchroniser.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, the load register (address 0), the divide register (address 1) and the remaining count (address 2) all read zero, and `expire` is low.
- R2: A write to address 1 keeps only bits 3, 1 and 0 of `wdata`. Bit 2 and all bits above bit 3 read back as zero, and the register changes on no other event.
- R3: The tick divisor is 2^s, where s = ({bit3, bit1, bit0} + 1) mod 8. Code 0xB gives a divisor of 1, code 0x0 gives 2, code 0x1 gives 4, code 0x3 gives 16, code 0x8 gives 32 and code 0xA gives 128.
- R4: The remaining count drops by one every 16 × divisor clock cycles, counted from the clock edge that loaded it.
- R5: A write to address 0 stores all 32 bits of `wdata`. The value reads back at address 0, and the remaining count restarts from it on the next cycle.
- R6: Address 2 is read-only and address 3 is unused. Writes to either leave every register unchanged, and address 3 reads zero.
- R7: When the remaining count steps from 1 to 0, `expire` is high for exactly one cycle. After that the count holds at zero and no further strobe occurs until the next load.
- R8: Loading zero stops the timer at once with a remaining count of zero and produces no expiry strobe.
- R9: Writing the divide register during a countdown does not change the tick length of that countdown. The new divisor applies from the next load onward.
- R10: Loading a new value during a countdown discards the old count and the partial tick, and restarts the countdown from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 2 | Register select: 0 load, 1 divide, 2 remaining count, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register selected by `addr` (combinational) |
| expire | output | 1 | Single-cycle strobe when the countdown reaches zero |

## Verification
The hardest case to reach is a divide-register write that lands inside a countdown that is already running. This must not stretch or shrink the tick that is in progress. The stimulus starts a two-tick countdown at divide-by-1, rewrites the divide register one cycle later to the longest code, and checks that the decrement and the strobe still arrive 16 and 32 cycles after the load. A fresh load then shows the long divisor taking effect, with the decrement landing exactly 2048 cycles after that load.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned CNT_W    = 32;
  localparam int unsigned CFG_W    = 4;
  localparam int unsigned SHIFT_W  = 3;
  localparam int unsigned PRESCALE = 16;
  localparam int unsigned ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_LOAD   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_REMAIN = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SPARE  = 2'd3;

  // only bits 3, 1 and 0 of the divide code are stored
  localparam logic [CFG_W-1:0] DIV_KEEP = 4'b1011;

  // shift = ({b3,b1,b0} + 1) wrapped to three bits
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [CFG_W-1:0] code);
    logic [SHIFT_W-1:0] raw;
    raw = {code[3], code[1:0]};
    return raw + 3'd1;
  endfunction

endpackage

// File: rtl/tmr_divcfg.sv
module tmr_divcfg
  import tmr_pkg::*;
#(
  parameter int unsigned W_CFG   = CFG_W,
  parameter int unsigned W_SHIFT = SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [W_CFG-1:0]   wdata,
  output logic [W_CFG-1:0]   cfg_q,
  output logic [W_SHIFT-1:0] shift
);

  logic [W_CFG-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata & DIV_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign shift = div_shift(cfg_q);

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned W_SHIFT = SHIFT_W,
  parameter int unsigned PRE     = PRESCALE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic [W_SHIFT-1:0] shift,
  output logic               tick
);

  localparam int unsigned PRE_W = $clog2(PRE);
  localparam int unsigned PER_W = PRE_W + (1 << W_SHIFT);

  logic [PER_W-1:0] term_q, term_d;
  logic [PER_W-1:0] pre_q,  pre_d;

  assign tick = run && (pre_q == term_q);

  always_comb begin
    term_d = term_q;
    pre_d  = pre_q;
    if (load) begin
      term_d = (PER_W'(PRE) << shift) - PER_W'(1);
      pre_d  = '0;
    end else if (run) begin
      if (tick) pre_d = '0;
      else      pre_d = pre_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      pre_q  <= '0;
    end else begin
      term_q <= term_d;
      pre_q  <= pre_d;
    end
  end

  // R4
  pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= term_q);

  // R9
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(term_q));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned W_CNT = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W_CNT-1:0] load_val,
  input  logic             tick,
  output logic [W_CNT-1:0] remain,
  output logic             active,
  output logic             expire
);

  logic [W_CNT-1:0] remain_d;
  logic             active_d;
  logic             expire_d;

  always_comb begin
    remain_d = remain;
    active_d = active;
    expire_d = 1'b0;
    if (load) begin
      remain_d = load_val;
      active_d = |load_val;
    end else if (tick) begin
      remain_d = remain - W_CNT'(1);
      if (remain == W_CNT'(1)) begin
        active_d = 1'b0;
        expire_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      active <= 1'b0;
      expire <= 1'b0;
    end else begin
      remain <= remain_d;
      active <= active_d;
      expire <= expire_d;
    end
  end

  // R7
  expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  // R7
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (remain == '0) && !active);

  // R8
  zero_load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_val == '0)) |=> (!active && !expire && remain == '0));

  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (remain <= $past(remain)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> $stable(remain));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W_CNT   = CNT_W,
  parameter int unsigned W_CFG   = CFG_W,
  parameter int unsigned W_ADDR  = ADDR_W,
  parameter int unsigned W_SHIFT = SHIFT_W,
  parameter int unsigned PRE     = PRESCALE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [W_ADDR-1:0] addr,
  input  logic [W_CNT-1:0]  wdata,
  output logic [W_CNT-1:0]  rdata,
  output logic              expire
);

  logic rst_meta, rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  logic               wr_load, wr_div;
  logic [W_CNT-1:0]   init_q, init_d;
  logic [W_CFG-1:0]   cfg_q;
  logic [W_SHIFT-1:0] shift;
  logic               tick;
  logic [W_CNT-1:0]   remain;
  logic               active;

  assign wr_load = wr_en && (addr == ADDR_LOAD);
  assign wr_div  = wr_en && (addr == ADDR_DIV);

  always_comb begin
    init_d = init_q;
    if (wr_load) init_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) init_q <= '0;
    else           init_q <= init_d;
  end

  tmr_divcfg #(.W_CFG(W_CFG), .W_SHIFT(W_SHIFT)) u_div (
    .clk   (clk),
    .rst_n (rst_core),
    .wr_en (wr_div),
    .wdata (wdata[W_CFG-1:0]),
    .cfg_q (cfg_q),
    .shift (shift)
  );

  tmr_prescale #(.W_SHIFT(W_SHIFT), .PRE(PRE)) u_pre (
    .clk   (clk),
    .rst_n (rst_core),
    .load  (wr_load),
    .run   (active),
    .shift (shift),
    .tick  (tick)
  );

  tmr_counter #(.W_CNT(W_CNT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core),
    .load     (wr_load),
    .load_val (wdata),
    .tick     (tick),
    .remain   (remain),
    .active   (active),
    .expire   (expire)
  );

  always_comb begin
    case (addr)
      ADDR_LOAD:   rdata = init_q;
      ADDR_DIV:    rdata = {{(W_CNT-W_CFG){1'b0}}, cfg_q};
      ADDR_REMAIN: rdata = remain;
      default:     rdata = '0;
    endcase
  end

  // R6
  remain_ro_chk: assert property (@(posedge clk) disable iff (!rst_core)
    (wr_en && addr == ADDR_REMAIN) |=> (remain <= $past(remain)) && $stable(init_q));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_core |-> !expire);

endmodule

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        expire;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned pulses   = 0;

  always #10 clk = ~clk;

  oneshot_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .expire(expire)
  );

  always @(negedge clk) if (expire) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); check("R1 load", v, 0);
    rd(2'd1, v); check("R1 div", v, 0);
    rd(2'd2, v); check("R1 remain", v, 0);
    check("R1 expire", {31'd0, expire}, 0);
  endtask

  task automatic t_cfg_mask;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R2 mask all-ones", v, 32'hB);
    wr(2'd1, 32'h0000_0004); rd(2'd1, v); check("R2 bit2 only", v, 0);
    wr(2'd1, 32'h0000_0009); rd(2'd1, v); check("R2 keep 9", v, 32'h9);
  endtask

  task automatic t_div_codes;
    logic [3:0] codes [6] = '{4'hB, 4'h0, 4'h1, 4'h3, 4'h8, 4'hA};
    int         pers  [6] = '{16, 32, 64, 256, 512, 2048};
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, {28'd0, codes[i]});
      wr(2'd0, 32'd3);
      step(pers[i] - 1);
      rd(2'd2, v); check($sformatf("R3 code %0h before tick", codes[i]), v, 3);
      step(1);
      rd(2'd2, v); check($sformatf("R4 code %0h after tick", codes[i]), v, 2);
      wr(2'd0, 32'd0);
    end
  endtask

  task automatic t_expire;
    logic [31:0] v;
    int unsigned base;
    base = pulses;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'd4);
    step(63);
    rd(2'd2, v); check("R7 remain before end", v, 1);
    check("R7 no early strobe", {31'd0, expire}, 0);
    step(1);
    rd(2'd2, v); check("R7 remain at end", v, 0);
    check("R7 strobe", {31'd0, expire}, 1);
    step(1);
    check("R7 strobe one cycle", {31'd0, expire}, 0);
    step(100);
    rd(2'd2, v); check("R7 hold zero", v, 0);
    check("R7 single pulse", pulses - base, 1);
  endtask

  task automatic t_zero_stop;
    logic [31:0] v;
    int unsigned base;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'd5);
    step(20);
    base = pulses;
    wr(2'd0, 32'd0);
    rd(2'd2, v); check("R8 stopped", v, 0);
    step(200);
    rd(2'd2, v); check("R8 still zero", v, 0);
    check("R8 no strobe", pulses - base, 0);
  endtask

  task automatic t_read_only;
    logic [31:0] v;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'd7);
    wr(2'd2, 32'h55);
    rd(2'd2, v); check("R6 remain unwritten", v, 7);
    wr(2'd3, 32'h99);
    rd(2'd3, v); check("R6 spare reads zero", v, 0);
    rd(2'd0, v); check("R5 load readback", v, 7);
    rd(2'd1, v); check("R6 div untouched", v, 32'hB);
    step(13);
    rd(2'd2, v); check("R6 count not disturbed", v, 7);
    step(1);
    rd(2'd2, v); check("R6 tick on time", v, 6);
    wr(2'd0, 32'd0);
  endtask

  task automatic t_cfg_midway;
    logic [31:0] v;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'd2);
    wr(2'd1, 32'hA);
    step(14);
    rd(2'd2, v); check("R9 before tick", v, 2);
    step(1);
    rd(2'd2, v); check("R9 old period kept", v, 1);
    step(15);
    check("R9 no early strobe", {31'd0, expire}, 0);
    step(1);
    check("R9 strobe on old period", {31'd0, expire}, 1);
    rd(2'd1, v); check("R9 new code stored", v, 32'hA);
    wr(2'd0, 32'd1);
    step(2047);
    rd(2'd2, v); check("R9 new period before", v, 1);
    step(1);
    rd(2'd2, v); check("R9 new period after", v, 0);
    check("R9 strobe on new period", {31'd0, expire}, 1);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'd10);
    step(20);
    rd(2'd2, v); check("R10 first run", v, 9);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R5 full width load", v, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R5 load readback", v, 32'hFFFF_FFFF);
    step(15);
    rd(2'd2, v); check("R10 partial tick dropped", v, 32'hFFFF_FFFF);
    step(1);
    rd(2'd2, v); check("R10 restart tick", v, 32'hFFFF_FFFE);
    wr(2'd0, 32'd0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    fork
      begin
        t_reset();
        t_cfg_mask();
        t_div_codes();
        t_expire();
        t_zero_stop();
        t_read_only();
        t_cfg_midway();
        t_reload();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule